// File: doc/BRIEF.md
# Timer Count-Enable Source Selector

This block turns a 4-bit source code into a count-enable strobe for a downstream timer. The strobe is exactly one system clock wide each time it fires. The code picks one of three kinds of source:

- the system clock itself;
- the system clock divided by a fixed power-of-two ratio;
- edge events taken from an asynchronous external clock pin.

All divided sources share one free-running prescaler counter. Because of this, changing the code never restarts the count. The new ratio takes effect on the very next cycle, counted from wherever the shared counter happens to be.

The external pin passes through a two-flop synchronizer. A history flop behind the synchronizer allows rising, falling or both edges to be selected. Codes above 1010 are reserved and keep the strobe low. The strobe leaves the block from a register.

Top module: `cnt_clk_sel`

## Requirements
- R1: While `rst` is high at a clock edge, `tick_o` is 0 after that edge. Reset clears the prescaler counter, so after any reset the divided strobes restart their phase from zero.
- R2: Code 0000 drives `tick_o` to 1 in every cycle, starting with the first edge after reset is released.
- R3: Codes 0001, 0010, 0011 and 0100 divide by 4, 16, 128 and 256. With the code held from reset, `tick_o` is 1 after edge k (counting from the first edge after release) exactly when k is a multiple of the ratio.
- R4: Codes 1000, 1001 and 1010 divide by 512, 1024 and 2048, with the same phase rule as R3.
- R5: Code 0101 gives one strobe per rising edge of `ext_clk_i`. If the pin changes before edge e, the strobe is high after edge e+2.
- R6: Code 0110 gives one strobe per falling edge of `ext_clk_i`, with the same latency as R5.
- R7: Code 0111 gives one strobe for every rising and every falling edge of `ext_clk_i`, with the same latency as R5.
- R8: Codes 1011 through 1111 never produce a strobe. A switch to such a code silences `tick_o` from the next edge on.
- R9: A new code takes effect at the next edge without restarting the prescaler. For example, switching from 0001 to 0010 after edge 5 gives the next strobe after edge 16.
- R10: In a divided mode with a stable code, a strobe is never followed directly by another strobe.
- R11: The edge history is cleared to low by reset. A pin that is already high when reset is released counts as one rising edge, so its strobe is high after the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk_i | input | 1 | Asynchronous external clock pin |
| sel_i | input | 4 | Source select code |
| tick_o | output | 1 | Registered one-cycle count-enable strobe |

## Verification
A wrong prescaler value shows up at the ports as a misplaced first strobe after reset, or after a code switch. It appears within one ratio period, so all divided codes are measured by their first strobe position and by their strobe count over a fixed window.

A fault in the synchronizer or in the edge history shifts the external strobe away from edge e+2, or changes how many strobes appear per pin transition. Both effects are visible within three cycles of a pin change.

A decode error puts strobes on a reserved code, or the wrong ratio on a valid code, within the measurement window.

// File: rtl/ccs_pkg.sv
package ccs_pkg;

  typedef enum logic [3:0] {
    SRC_SYS      = 4'h0,
    SRC_DIV4     = 4'h1,
    SRC_DIV16    = 4'h2,
    SRC_DIV128   = 4'h3,
    SRC_DIV256   = 4'h4,
    SRC_EXT_RISE = 4'h5,
    SRC_EXT_FALL = 4'h6,
    SRC_EXT_BOTH = 4'h7,
    SRC_DIV512   = 4'h8,
    SRC_DIV1024  = 4'h9,
    SRC_DIV2048  = 4'hA
  } src_sel_e;

  localparam int NUM_TAPS  = 7;
  localparam int MAX_LOG2  = 11;
  localparam int SYNC_DEPTH = 2;

  // log2 of the divide ratio served by each prescaler tap
  function automatic int tap_log2(input int idx);
    case (idx)
      0:       return 2;
      1:       return 4;
      2:       return 7;
      3:       return 8;
      4:       return 9;
      5:       return 10;
      default: return 11;
    endcase
  endfunction

  function automatic logic is_div_code(input logic [3:0] code);
    return (code >= 4'h1 && code <= 4'h4) || (code >= 4'h8 && code <= 4'hA);
  endfunction

endpackage

// File: rtl/ccs_prescaler.sv
module ccs_prescaler #(
  parameter int CNT_W = ccs_pkg::MAX_LOG2
) (
  input  logic                          clk,
  input  logic                          rst,
  output logic [ccs_pkg::NUM_TAPS-1:0]  tap_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  // each tap fires when the low log2(ratio) bits of the shared counter are all ones
  for (genvar g = 0; g < ccs_pkg::NUM_TAPS; g++) begin : g_tap
    localparam int L = ccs_pkg::tap_log2(g);
    assign tap_o[g] = &cnt_q[L-1:0];
  end

endmodule

// File: rtl/ccs_edge_detect.sv
module ccs_edge_detect #(
  parameter int STAGES = ccs_pkg::SYNC_DEPTH
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] sync_q;
  logic              hist_q;
  logic              level;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      hist_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      hist_q <= sync_q[STAGES-1];
    end
  end

  assign level  = sync_q[STAGES-1];
  assign rise_o = level & ~hist_q;
  assign fall_o = ~level & hist_q;

endmodule

// File: rtl/ccs_src_mux.sv
module ccs_src_mux (
  input  logic [3:0]                   sel_i,
  input  logic [ccs_pkg::NUM_TAPS-1:0] tap_i,
  input  logic                         rise_i,
  input  logic                         fall_i,
  output logic                         tick_d_o
);
  import ccs_pkg::*;

  always_comb begin
    case (sel_i)
      SRC_SYS:      tick_d_o = 1'b1;
      SRC_DIV4:     tick_d_o = tap_i[0];
      SRC_DIV16:    tick_d_o = tap_i[1];
      SRC_DIV128:   tick_d_o = tap_i[2];
      SRC_DIV256:   tick_d_o = tap_i[3];
      SRC_EXT_RISE: tick_d_o = rise_i;
      SRC_EXT_FALL: tick_d_o = fall_i;
      SRC_EXT_BOTH: tick_d_o = rise_i | fall_i;
      SRC_DIV512:   tick_d_o = tap_i[4];
      SRC_DIV1024:  tick_d_o = tap_i[5];
      SRC_DIV2048:  tick_d_o = tap_i[6];
      default:      tick_d_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/cnt_clk_sel.sv
module cnt_clk_sel #(
  parameter int PRE_W      = ccs_pkg::MAX_LOG2,
  parameter int SYNC_DEPTH = ccs_pkg::SYNC_DEPTH
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ext_clk_i,
  input  logic [3:0] sel_i,
  output logic       tick_o
);

  logic [ccs_pkg::NUM_TAPS-1:0] tap;
  logic                         rise;
  logic                         fall;
  logic                         tick_d;

  ccs_prescaler #(.CNT_W(PRE_W)) u_pre (
    .clk   (clk),
    .rst   (rst),
    .tap_o (tap)
  );

  ccs_edge_detect #(.STAGES(SYNC_DEPTH)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .pin_i  (ext_clk_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  ccs_src_mux u_mux (
    .sel_i    (sel_i),
    .tap_i    (tap),
    .rise_i   (rise),
    .fall_i   (fall),
    .tick_d_o (tick_d)
  );

  always_ff @(posedge clk) begin
    if (rst) tick_o <= 1'b0;
    else     tick_o <= tick_d;
  end

endmodule

// File: rtl/ccs_checker.sv
module ccs_checker (
  input logic       clk,
  input logic       rst,
  input logic [3:0] sel_i,
  input logic       tick_o
);

  // R1: the cycle that leaves reset starts with the strobe low
  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !tick_o);

  // R2: the system-clock code strobes on every cycle
  assert_every_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(sel_i) == 4'h0 && !$past(rst)) |-> tick_o);

  // R8: reserved codes stay silent
  assert_reserved_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(sel_i) > 4'hA) |-> !tick_o);

  // R10: divided strobes are isolated while the code is stable
  assert_single_width_R10: assert property (@(posedge clk) disable iff (rst)
    (tick_o && ccs_pkg::is_div_code($past(sel_i)) && $stable(sel_i)) |=> !tick_o);

endmodule

bind cnt_clk_sel ccs_checker u_chk (
  .clk    (clk),
  .rst    (rst),
  .sel_i  (sel_i),
  .tick_o (tick_o)
);

// File: tb/cnt_clk_sel_test.sv
module cnt_clk_sel_test;

  localparam int W = 4200;

  localparam int EXP_CNT [16] = '{4200, 1050, 262, 32, 16, 10, 9, 19,
                                  8, 4, 2, 0, 0, 0, 0, 0};
  localparam int EXP_FIRST [16] = '{1, 4, 16, 128, 256, 12, 22, 12,
                                    512, 1024, 2048, 0, 0, 0, 0, 0};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ext = 1'b0;
  logic [3:0] sel = 4'h0;
  logic       tick;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  cnt_clk_sel uut (
    .clk       (clk),
    .rst       (rst),
    .ext_clk_i (ext),
    .sel_i     (sel),
    .tick_o    (tick)
  );

  function automatic string req_of(input logic [3:0] c);
    case (c)
      4'h0:                return "R2";
      4'h1, 4'h2, 4'h3, 4'h4: return "R3";
      4'h5:                return "R5";
      4'h6:                return "R6";
      4'h7:                return "R7";
      4'h8, 4'h9, 4'hA:    return "R4";
      default:             return "R8";
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [3:0] s, input logic e);
    @(negedge clk);
    rst = 1'b1;
    sel = s;
    ext = e;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    // R1: strobe low while reset is held with the always-on code
    do_reset(4'h0, 1'b0);
    check("R1", "tick during reset", int'(tick), 0);

    // table walk: each code from reset, same pin pattern
    for (int v = 0; v < 16; v++) begin
      int cnt;
      int first;
      cnt = 0;
      first = 0;
      do_reset(v[3:0], 1'b0);
      for (int n = 1; n <= W; n++) begin
        if (n % 10 == 0 && n < 200) ext = ~ext;
        step();
        if (tick) begin
          cnt++;
          if (first == 0) first = n;
        end
      end
      check(req_of(v[3:0]), $sformatf("count code %0d", v), cnt, EXP_CNT[v]);
      check(req_of(v[3:0]), $sformatf("first strobe code %0d", v), first, EXP_FIRST[v]);
    end

    // R9: divide-by-4 then switch to divide-by-16 after edge 5
    begin
      int first;
      first = 0;
      do_reset(4'h1, 1'b0);
      for (int n = 1; n <= 5; n++) begin
        step();
        if (n == 4) check("R9", "div4 strobe at edge 4", int'(tick), 1);
      end
      sel = 4'h2;
      for (int n = 6; n <= 40; n++) begin
        step();
        if (tick && first == 0) first = n;
      end
      check("R9", "first div16 strobe after switch", first, 16);
    end

    // R8: switching to a reserved code silences the next edge; R2 returns
    begin
      do_reset(4'h0, 1'b0);
      repeat (5) step();
      sel = 4'hF;
      step();
      check("R8", "tick after switch to 1111", int'(tick), 0);
      step();
      check("R8", "tick one later on 1111", int'(tick), 0);
      sel = 4'h0;
      step();
      check("R2", "tick after return to 0000", int'(tick), 1);
    end

    // R1: reset mid-run restarts prescaler phase
    begin
      int first;
      first = 0;
      do_reset(4'h1, 1'b0);
      repeat (6) step();
      do_reset(4'h1, 1'b0);
      for (int n = 1; n <= 8; n++) begin
        step();
        if (tick && first == 0) first = n;
      end
      check("R1", "first div4 strobe after mid-run reset", first, 4);
    end

    // R11: pin high through reset counts as one rising edge
    begin
      int first;
      int cnt;
      first = 0;
      cnt = 0;
      do_reset(4'h5, 1'b1);
      for (int n = 1; n <= 10; n++) begin
        step();
        if (tick) begin
          cnt++;
          if (first == 0) first = n;
        end
      end
      check("R11", "first strobe with pin high", first, 3);
      check("R11", "strobe count with pin held high", cnt, 1);
    end

    // R7: back-to-back pin transitions in both-edge mode each give a strobe
    begin
      int cnt;
      cnt = 0;
      do_reset(4'h7, 1'b0);
      for (int n = 1; n <= 12; n++) begin
        if (n >= 2 && n <= 5) ext = ~ext;
        step();
        if (tick) cnt++;
      end
      check("R7", "strobes for four fast transitions", cnt, 4);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule